// File: doc/BRIEF.md
# Multiplexed ADC Control-Word Sequencer

This block is the host-side serial master for an eight-input, 12-bit converter. The converter takes an 8-bit write-only control word and returns a 16-bit result inside the same 16-clock frame. A host hands the block one request at a time through a valid/ready handshake. Each request carries the channel to sample next and the power mode to program, and acceptance starts a frame. The block lowers chip select, clocks out the control word, gathers the returned word and raises chip select again.

The converter uses the channel written in a frame for the conversion carried by the next frame. The block therefore tags every result with the channel sent one frame earlier. The first result after reset is marked invalid, because no channel had been programmed when it was taken. If the previously written mode lets the converter power itself down after each conversion, the block holds chip select low with the serial clock parked for a wake-up interval before the first clock. Serial clock half-periods and the wake-up interval are parameters counted in system-clock cycles.

Top module: `adc_ctrl_sequencer`

## Requirements
- R1: After reset, and whenever no frame is running, cs_n=1, sclk=1, sdi=0, req_ready=1 and res_valid=0.
- R2: A frame holds cs_n low for exactly 16 rising sclk edges. Each sclk period is a low half followed by a high half, and each half lasts CLK_DIV system cycles. Without a wake-up wait, sclk goes low in the first cycle in which cs_n is low.
- R3: During the first 8 sclk periods, sdi presents the control word MSB first and changes only while sclk is low. Bit 7 is a don't-care driven 0, bit 6 is 0, bits 5:3 are the channel, bit 2 is 0 and bits 1:0 are the power mode.
- R4: sdi is 0 during sclk periods 9 to 16.
- R5: sdo is sampled at each rising sclk edge. The first 4 sampled bits are discarded, and the last 12 form res_data, MSB first.
- R6: res_chan is the channel sent in the previous frame, or 0 when there was none.
- R7: res_ok is 0 for the first result after reset and 1 for every later result.
- R8: If the mode sent in the previous frame has bit 1 set (codes 2 and 3 select auto power-down), sclk stays high for WAKE_CYC cycles after cs_n falls before its first falling edge. The mode of the current request does not trigger the wait, and the first frame after reset never waits.
- R9: req_ready is 0 while a frame runs. A request held through a frame is taken once the block is idle again, and the block uses the channel and mode present when the request is taken.
- R10: res_valid is a one-cycle pulse in the cycle in which cs_n returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; starts a frame when accepted |
| req_chan | input | 3 | Channel to program for the next conversion |
| req_mode | input | 2 | Power mode to program |
| req_ready | output | 1 | Block idle and able to accept a request |
| cs_n | output | 1 | Active-low chip select to the converter |
| sclk | output | 1 | Serial clock to the converter, idles high |
| sdi | output | 1 | Serial data to the converter's control register |
| sdo | input | 1 | Serial result data from the converter |
| res_valid | output | 1 | Result pulse |
| res_ok | output | 1 | Result belongs to a programmed channel |
| res_chan | output | 3 | Channel tag of the result |
| res_data | output | 12 | Conversion result |

## Verification
The checker watches the serial framing on every cycle. It checks that sclk is parked high while deselected, that each frame closes after exactly sixteen rising edges, that sdi moves only while sclk is low and stays quiet in the second half of the frame, and that the result pulse lines up with the rise of chip select and carries the correct validity flag. Some behaviour shows only in the bench's scenarios, which compare every cycle against a timeline model. These are the exact control-word bits for each channel and mode, the removal of the leading result bits, the one-frame-late channel tag, the wake-up wait that appears only after a frame that wrote an auto power-down mode, and the clearing of that history by a reset.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CH_W       = 3;
    localparam int MODE_W     = 2;
    localparam int CTRL_W     = 8;
    localparam int FRAME_CLKS = 16;
    localparam int RES_W      = 12;
    localparam int HALF_N     = 2 * FRAME_CLKS;
    localparam int HALF_W     = $clog2(HALF_N);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAKE,
        ST_SHIFT,
        ST_CLOSE
    } seq_state_e;

    typedef struct packed {
        logic [CH_W-1:0]   chan;
        logic [MODE_W-1:0] mode;
    } seq_req_t;

    // Control word as the converter decodes it, MSB shifted first.
    function automatic logic [CTRL_W-1:0] build_ctrl(seq_req_t r);
        return {1'b0, 1'b0, r.chan, 1'b0, r.mode};
    endfunction

    // Codes with bit 1 set leave the converter asleep after a conversion.
    function automatic logic mode_sleeps(logic [MODE_W-1:0] m);
        return m[1];
    endfunction

endpackage

// File: rtl/adc_seq_tick.sv
module adc_seq_tick #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt;

    assign hit = (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || clr || hit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_seq_shift.sv
module adc_seq_shift
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              adv,
    input  logic              cap,
    input  logic              sdo,
    output logic              tx_msb,
    output logic [RES_W-1:0]  rx
);
    logic [CTRL_W-1:0] tx;

    assign tx_msb = tx[CTRL_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx <= '0;
            rx <= '0;
        end else if (load) begin
            tx <= ctrl;
            rx <= '0;
        end else begin
            if (adv) tx <= {tx[CTRL_W-2:0], 1'b0};
            if (cap) rx <= {rx[RES_W-2:0], sdo};
        end
    end
endmodule

// File: rtl/adc_seq_tag.sv
module adc_seq_tag
    import adc_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  seq_req_t        req,
    input  logic            close,
    output logic [CH_W-1:0] prev_chan,
    output logic            prev_ok,
    output logic            wake_need
);
    logic [CH_W-1:0] cur_chan;
    logic            cur_sleep;
    logic            prev_sleep;

    assign wake_need = prev_ok && prev_sleep;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_chan   <= '0;
            cur_sleep  <= 1'b0;
            prev_chan  <= '0;
            prev_ok    <= 1'b0;
            prev_sleep <= 1'b0;
        end else begin
            if (load) begin
                cur_chan  <= req.chan;
                cur_sleep <= mode_sleeps(req.mode);
            end
            if (close) begin
                prev_chan  <= cur_chan;
                prev_sleep <= cur_sleep;
                prev_ok    <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/adc_ctrl_sequencer.sv
module adc_ctrl_sequencer
    import adc_seq_pkg::*;
#(
    parameter int CLK_DIV  = 4,
    parameter int WAKE_CYC = 625
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic [CH_W-1:0]         req_chan,
    input  logic [MODE_W-1:0]       req_mode,
    output logic                    req_ready,
    output logic                    cs_n,
    output logic                    sclk,
    output logic                    sdi,
    input  logic                    sdo,
    output logic                    res_valid,
    output logic                    res_ok,
    output logic [CH_W-1:0]         res_chan,
    output logic [RES_W-1:0]        res_data
);
    localparam int MAXC  = (CLK_DIV > WAKE_CYC) ? CLK_DIV : WAKE_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0]  HALF_LIM = CNT_W'(CLK_DIV - 1);
    localparam logic [CNT_W-1:0]  WAKE_LIM = CNT_W'(WAKE_CYC - 1);
    localparam logic [HALF_W-1:0] LAST_H   = HALF_W'(HALF_N - 1);

    seq_state_e        state;
    logic [HALF_W-1:0] half;
    logic              hit;
    logic              take;
    logic              wake_need;
    logic              tx_msb;
    seq_req_t          req;

    assign req       = '{chan: req_chan, mode: req_mode};
    assign take      = (state == ST_IDLE) && req_valid;
    assign req_ready = (state == ST_IDLE);
    assign cs_n      = (state == ST_IDLE) || (state == ST_CLOSE);
    assign sclk      = !((state == ST_SHIFT) && !half[0]);
    assign sdi       = (state == ST_SHIFT) && tx_msb;
    assign res_valid = (state == ST_CLOSE);

    adc_seq_tick #(.W(CNT_W)) u_tick (
        .clk   (clk),
        .rst   (rst),
        .clr   ((state == ST_IDLE) || (state == ST_CLOSE)),
        .limit ((state == ST_WAKE) ? WAKE_LIM : HALF_LIM),
        .hit   (hit)
    );

    adc_seq_shift u_shift (
        .clk    (clk),
        .rst    (rst),
        .load   (take),
        .ctrl   (build_ctrl(req)),
        .adv    ((state == ST_SHIFT) && hit && half[0]),
        .cap    ((state == ST_SHIFT) && hit && !half[0]),
        .sdo    (sdo),
        .tx_msb (tx_msb),
        .rx     (res_data)
    );

    adc_seq_tag u_tag (
        .clk       (clk),
        .rst       (rst),
        .load      (take),
        .req       (req),
        .close     (state == ST_CLOSE),
        .prev_chan (res_chan),
        .prev_ok   (res_ok),
        .wake_need (wake_need)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            half  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    half <= '0;
                    if (req_valid) state <= wake_need ? ST_WAKE : ST_SHIFT;
                end
                ST_WAKE: begin
                    if (hit) state <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (hit) begin
                        half <= half + 1'b1;
                        if (half == LAST_H) state <= ST_CLOSE;
                    end
                end
                ST_CLOSE: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic sclk,
    input logic sdi,
    input logic req_ready,
    input logic res_valid,
    input logic res_ok
);
    logic [4:0] rise_cnt;
    logic       sclk_q;
    logic       seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_cnt <= '0;
            sclk_q   <= 1'b1;
            seen     <= 1'b0;
        end else begin
            sclk_q <= sclk;
            if (cs_n) rise_cnt <= '0;
            else if (sclk && !sclk_q) rise_cnt <= rise_cnt + 1'b1;
            if (res_valid) seen <= 1'b1;
        end
    end

    assert_park_high_R1: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> sclk);

    assert_sixteen_edges_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> (rise_cnt == 5'd16));

    assert_sdi_on_low_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdi) |-> !sclk);

    assert_dontcare_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && rise_cnt == 5'd0) |-> !sdi);

    assert_quiet_tail_R4: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !sclk && rise_cnt >= 5'd8) |-> !sdi);

    assert_first_invalid_R7: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !seen) |-> !res_ok);

    assert_later_valid_R7: assert property (@(posedge clk) disable iff (rst)
        (res_valid && seen) |-> res_ok);

    assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> cs_n);

    assert_pulse_at_close_R10: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $rose(cs_n));

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);
endmodule

bind adc_ctrl_sequencer adc_seq_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .sdi       (sdi),
    .req_ready (req_ready),
    .res_valid (res_valid),
    .res_ok    (res_ok)
);

// File: tb/tb_adc_ctrl_sequencer.sv
module tb_adc_ctrl_sequencer;
    localparam int CDIV = 2;
    localparam int WAKE = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_chan = '0;
    logic [1:0]  req_mode = '0;
    logic        sdo = 1'b0;
    logic        req_ready, cs_n, sclk, sdi, res_valid, res_ok;
    logic [2:0]  res_chan;
    logic [11:0] res_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    adc_ctrl_sequencer #(.CLK_DIV(CDIV), .WAKE_CYC(WAKE)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_chan(req_chan),
        .req_mode(req_mode), .req_ready(req_ready), .cs_n(cs_n), .sclk(sclk),
        .sdi(sdi), .sdo(sdo), .res_valid(res_valid), .res_ok(res_ok),
        .res_chan(res_chan), .res_data(res_data)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: got %0h expected %0h", rq, $time, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    task automatic idle_gap(input int n);
        for (int i = 0; i < n; i++) begin
            chk(cs_n == 1'b1, "R1", int'(cs_n), 1);
            chk(sclk == 1'b1, "R1", int'(sclk), 1);
            chk(sdi == 1'b0, "R1", int'(sdi), 0);
            chk(req_ready == 1'b1, "R1", int'(req_ready), 1);
            chk(res_valid == 1'b0, "R1", int'(res_valid), 0);
            @(negedge clk);
        end
    endtask

    // Timeline model of one frame, checked every cycle at the falling clk edge.
    task automatic run_frame(input int ch, input int md, input logic [15:0] word,
                             input int exp_ok, input int exp_ch, input bit wake,
                             input bit hold, input int nch, input int nmd);
        logic [7:0] cw;
        cw = {2'b00, 3'(ch), 1'b0, 2'(md)};
        chk(req_ready == 1'b1, "R9", int'(req_ready), 1);
        chk(cs_n == 1'b1, "R2", int'(cs_n), 1);
        req_valid = 1'b1;
        req_chan  = 3'(ch);
        req_mode  = 2'(md);
        @(negedge clk);
        if (hold) begin
            req_chan = 3'(nch);
            req_mode = 2'(nmd);
        end else begin
            req_valid = 1'b0;
            req_chan  = ~3'(ch);
            req_mode  = 2'b11;
        end
        if (wake) begin
            for (int w = 0; w < WAKE; w++) begin
                chk(cs_n == 1'b0, "R8", int'(cs_n), 0);
                chk(sclk == 1'b1, "R8", int'(sclk), 1);
                chk(sdi == 1'b0, "R3", int'(sdi), 0);
                chk(req_ready == 1'b0, "R9", int'(req_ready), 0);
                @(negedge clk);
            end
        end
        for (int h = 0; h < 32; h++) begin
            for (int c = 0; c < CDIV; c++) begin
                int es;
                int ed;
                if (h % 2 == 0 && c == 0) sdo = word[15 - h/2];
                es = h % 2;
                ed = (h < 16) ? int'(cw[7 - h/2]) : 0;
                chk(cs_n == 1'b0, "R2", int'(cs_n), 0);
                chk(int'(sclk) == es, wake ? "R8" : "R2", int'(sclk), es);
                chk(int'(sdi) == ed, (h < 16) ? "R3" : "R4", int'(sdi), ed);
                chk(req_ready == 1'b0, "R9", int'(req_ready), 0);
                chk(res_valid == 1'b0, "R10", int'(res_valid), 0);
                @(negedge clk);
            end
        end
        chk(cs_n == 1'b1, "R2", int'(cs_n), 1);
        chk(res_valid == 1'b1, "R10", int'(res_valid), 1);
        chk(res_data == word[11:0], "R5", int'(res_data), int'(word[11:0]));
        chk(int'(res_chan) == exp_ch, "R6", int'(res_chan), exp_ch);
        chk(int'(res_ok) == exp_ok, "R7", int'(res_ok), exp_ok);
        @(negedge clk);
        chk(res_valid == 1'b0, "R10", int'(res_valid), 0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
        $finish;
    end

    initial begin
        do_reset();
        // R1: idle state after reset
        idle_gap(3);
        // First result after reset is untagged (R7), no wait on first frame (R8)
        run_frame(5, 0, 16'hF123, 0, 0, 1'b0, 1'b0, 0, 0);
        // Auto power-down requested now; no wait yet (R8), tag is channel 5 (R6)
        run_frame(2, 2, 16'h0FFF, 1, 5, 1'b0, 1'b0, 0, 0);
        idle_gap(2);
        // Previous mode was auto power-down: wake wait expected (R8)
        run_frame(7, 0, 16'h9000, 1, 2, 1'b1, 1'b0, 0, 0);
        // Mode 3 also sleeps; request held through frame (R9)
        run_frame(0, 3, 16'h6ABC, 1, 7, 1'b0, 1'b1, 3, 1);
        // Held request taken right away, wake wait after mode 3 (R8, R9)
        run_frame(3, 1, 16'h5555, 1, 0, 1'b1, 1'b0, 0, 0);
        // Mode 1 does not sleep: no wait (R8)
        run_frame(4, 2, 16'h3AAA, 1, 3, 1'b0, 1'b0, 0, 0);
        idle_gap(1);
        // Reset clears history: invalid result, channel 0, no wait (R7, R8)
        do_reset();
        idle_gap(2);
        run_frame(1, 0, 16'h0001, 0, 0, 1'b0, 1'b0, 0, 0);
        run_frame(6, 0, 16'hE800, 1, 1, 1'b0, 1'b0, 0, 0);
        idle_gap(2);
        report();
        $finish;
    end
endmodule